// File: doc/BRIEF.md
# Asynchronous Serial Interface Adapter

This block is a byte-wide asynchronous serial transmitter and receiver run from a small register bus. The host programs one write-only control byte. That byte picks a fixed clock divide ratio (one, sixteen or sixty-four ticks per bit) or holds the device in master reset. It also picks one of eight character framings, sets the RTS pin level, the transmit interrupt and a forced break, and enables the receive interrupt. A read-only status byte reports both data-register states, the two modem inputs, three receive error flags and a combined interrupt request.

Register select low addresses control (on write) and status (on read). Register select high addresses the transmit data register (on write) and the receive data register (on read). Reads are combinational. Writes and read side effects take effect on the rising clock edge that samples the strobe. A bit tick is produced every `PRESCALE` clocks and feeds both directions.

Top module: `sio_adapter`

## Requirements
- R1: After reset the control byte is 0x03 (master reset held). Status then reads 0x02 with both modem inputs low, `txd` is high, and `rts_out` and `irq_out` are low.
- R2: Control bits [1:0] give ticks per bit: 0 is 1, 1 is 16, 2 is 64. Value 3 holds master reset, which works as follows:
  - It clears receive-full and the framing, overrun and parity flags.
  - It sets transmit-empty and stops the shifter, leaving `txd` high.
  - Transmit data writes and receive data reads have no effect while it is held.
- R3: Control bits [4:2] pick the framing:
  - 0 is 7 data bits, even parity, 2 stop bits. 1 is 7 data bits, odd parity, 2 stop bits.
  - 2 is 7 data bits, even parity, 1 stop bit. 3 is 7 data bits, odd parity, 1 stop bit.
  - 4 is 8 data bits, no parity, 2 stop bits. 5 is 8 data bits, no parity, 1 stop bit.
  - 6 is 8 data bits, even parity, 1 stop bit. 7 is 8 data bits, odd parity, 1 stop bit.
  - A frame is a low start bit, the data bits least significant first, the optional parity bit, then the high stop bits.
  - Even parity makes the count of ones over data and parity even.
- R4: A transmit data write clears transmit-empty (status bit 1). When the shifter is idle, the byte moves into it on the next clock, and transmit-empty is set again. A write while the shifter is busy keeps transmit-empty low until that frame ends.
- R5: On `txd`, the start bit begins the clock after the byte moves into the shifter. Each bit lasts exactly ticks-per-bit ticks.
- R6: Control bits [6:5] set transmit control:
  - 0: RTS low, transmit interrupt off.
  - 1: RTS low, transmit interrupt on.
  - 2: RTS high, transmit interrupt off.
  - 3: RTS low, transmit interrupt off, and `txd` forced low (break) regardless of the shifter.
- R7: The receiver samples each bit at mid-bit. It places the character in the receive data register with bit 7 zero for 7-bit framings, and sets receive-full (status bit 0).
- R8: Status bit 6 flags a parity mismatch on the received character. Status bit 4 flags a framing error when the first stop bit samples low. Only the first stop bit is checked.
- R9: A character that completes while receive-full is still set sets overrun (status bit 5) and is discarded. The data register keeps the earlier character.
- R10: Reading the receive data register clears receive-full, overrun and parity error. The framing flag stays until the next stored character.
- R11: Status bit 2 follows `dcd_in` and status bit 3 follows `cts_in`.
- R12: The interrupt request is high when either of two conditions holds; it is output on `irq_out` and as status bit 7:
  - receive-full is set and control bit 7 is set;
  - transmit-empty is set and transmit control is 1.
- R13: At 16 or 64 ticks per bit, a start bit is accepted only if the line is still low half a bit after the falling edge. A shorter low pulse is ignored. At 1 tick per bit, the line is taken as externally synchronised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | 0: control/status, 1: transmit/receive data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (side effects on the data register) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (status or receive data) |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| cts_in | input | 1 | Clear-to-send level |
| dcd_in | input | 1 | Carrier-detect level |
| rts_out | output | 1 | RTS pin level |
| irq_out | output | 1 | Interrupt request |

## Verification
The bench builds the block with `PRESCALE` at 1, so a tick arrives every clock. At that setting the 1-tick mode moves one bit per clock, and `txd` can be checked at exact cycle positions. A 64-tick frame then takes about 700 clocks, so every divide ratio and all eight framings fit in one run, including a loopback of `txd` into `rxd`. The bench drives parity, framing, overrun and short-glitch cases at 1 or 16 ticks per bit, where the mid-bit sampling point is known exactly.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = 11;

  typedef enum logic [1:0] {DIV_1 = 2'd0, DIV_16 = 2'd1, DIV_64 = 2'd2, DIV_RST = 2'd3} div_sel_e;
  typedef enum logic [1:0] {TXC_LO_QUIET = 2'd0, TXC_LO_IRQ = 2'd1,
                            TXC_HI_QUIET = 2'd2, TXC_LO_BREAK = 2'd3} txc_e;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_e;

  typedef struct packed {
    logic       rx_ie;
    logic [1:0] txc;
    logic [2:0] fmt;
    logic [1:0] div;
  } ctrl_t;

  function automatic logic [6:0] div_ticks(input logic [1:0] d);
    case (d)
      2'd0:    return 7'd1;
      2'd1:    return 7'd16;
      default: return 7'd64;
    endcase
  endfunction

  function automatic logic [3:0] data_bits(input logic [2:0] f);
    return f[2] ? 4'd8 : 4'd7;
  endfunction

  function automatic logic has_parity(input logic [2:0] f);
    return !(f == 3'd4 || f == 3'd5);
  endfunction

  // odd parity formats are the odd codes
  function automatic logic odd_parity(input logic [2:0] f);
    return f[0];
  endfunction

  function automatic logic [3:0] stop_bits(input logic [2:0] f);
    return (f == 3'd0 || f == 3'd1 || f == 3'd4) ? 4'd2 : 4'd1;
  endfunction

  function automatic logic [3:0] frame_len(input logic [2:0] f);
    return 4'd1 + data_bits(f) + {3'b000, has_parity(f)} + stop_bits(f);
  endfunction

  function automatic logic [DATA_W-1:0] mask_data(input logic [2:0] f, input logic [DATA_W-1:0] d);
    return (data_bits(f) == 4'd8) ? d : {1'b0, d[DATA_W-2:0]};
  endfunction

  function automatic logic parity_of(input logic [2:0] f, input logic [DATA_W-1:0] d);
    return (^mask_data(f, d)) ^ odd_parity(f);
  endfunction

  // bit 0 goes out first; unused upper bits are idle high
  function automatic logic [FRAME_W-1:0] build_frame(input logic [2:0] f, input logic [DATA_W-1:0] d);
    logic [FRAME_W-1:0] fr;
    fr = '1;
    fr[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i < int'(data_bits(f))) fr[1+i] = d[i];
    if (has_parity(f)) fr[4'd1 + data_bits(f)] = parity_of(f, d);
    return fr;
  endfunction

  function automatic logic irq_req(input logic rdrf, input logic tdre, input ctrl_t c);
    return (rdrf && c.rx_ie) || (tdre && (c.txc == TXC_LO_IRQ));
  endfunction
endpackage

// File: rtl/sio_tx.sv
module sio_tx
  import sio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tick,
  input  logic [1:0]        div,
  input  logic [2:0]        fmt,
  input  logic              wr_data,
  input  logic [DATA_W-1:0] wdata,
  input  logic              brk,
  output logic              txd,
  output logic              tdre,
  output logic              busy,
  output logic              load_evt
);
  logic [DATA_W-1:0]  hold_q;
  logic [FRAME_W-1:0] shift_q;
  logic [3:0]         left_q;
  logic [6:0]         phase_q;
  logic               bit_end;

  assign load_evt = !busy && !tdre && !wr_data && !clr;
  assign bit_end  = busy && tick && (phase_q == div_ticks(div) - 7'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      tdre    <= 1'b1;
      busy    <= 1'b0;
      shift_q <= '1;
      left_q  <= '0;
      phase_q <= '0;
    end else if (clr) begin
      tdre    <= 1'b1;
      busy    <= 1'b0;
      shift_q <= '1;
      left_q  <= '0;
      phase_q <= '0;
    end else begin
      if (wr_data) begin
        hold_q <= wdata;
        tdre   <= 1'b0;
      end else if (load_evt) begin
        tdre <= 1'b1;
      end
      if (load_evt) begin
        shift_q <= build_frame(fmt, hold_q);
        left_q  <= frame_len(fmt);
        phase_q <= '0;
        busy    <= 1'b1;
      end else if (busy && tick) begin
        if (bit_end) begin
          phase_q <= '0;
          shift_q <= {1'b1, shift_q[FRAME_W-1:1]};
          left_q  <= left_q - 4'd1;
          if (left_q == 4'd1) busy <= 1'b0;
        end else begin
          phase_q <= phase_q + 7'd1;
        end
      end
    end
  end

  assign txd = brk ? 1'b0 : (busy ? shift_q[0] : 1'b1);
endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tick,
  input  logic [1:0]        div,
  input  logic [2:0]        fmt,
  input  logic              rxd,
  input  logic              rd_ack,
  output logic [DATA_W-1:0] rx_data,
  output logic              rdrf,
  output logic              fe,
  output logic              ovrn,
  output logic              pe,
  output logic              frame_end,
  output logic              load_evt,
  output logic              lost_evt
);
  rx_state_e         state_q;
  logic [6:0]        phase_q;
  logic [3:0]        idx_q;
  logic [9:0]        bits_q;
  logic [9:0]        cur;
  logic [6:0]        full_m1, half_m1;
  logic [3:0]        last_idx;
  logic              sample;
  logic [DATA_W-1:0] dword;
  logic              par_bad;

  assign full_m1  = div_ticks(div) - 7'd1;
  assign half_m1  = (div_ticks(div) >> 1) - 7'd1;
  assign last_idx = data_bits(fmt) + {3'b000, has_parity(fmt)};
  assign sample   = (state_q == RX_BITS) && tick && (phase_q == full_m1);

  always_comb begin
    cur        = bits_q;
    cur[idx_q] = rxd;
  end

  assign dword     = mask_data(fmt, cur[DATA_W-1:0]);
  assign par_bad   = has_parity(fmt) && (cur[data_bits(fmt)] != parity_of(fmt, dword));
  assign frame_end = sample && (idx_q == last_idx);
  assign load_evt  = frame_end && (!rdrf || rd_ack);
  assign lost_evt  = frame_end && rdrf && !rd_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      phase_q <= '0;
      idx_q   <= '0;
      bits_q  <= '0;
      rx_data <= '0;
      rdrf    <= 1'b0;
      fe      <= 1'b0;
      ovrn    <= 1'b0;
      pe      <= 1'b0;
    end else if (clr) begin
      state_q <= RX_IDLE;
      phase_q <= '0;
      idx_q   <= '0;
      rx_data <= '0;
      rdrf    <= 1'b0;
      fe      <= 1'b0;
      ovrn    <= 1'b0;
      pe      <= 1'b0;
    end else begin
      if (tick) begin
        case (state_q)
          RX_IDLE: if (!rxd) begin
            phase_q <= '0;
            idx_q   <= '0;
            state_q <= (div == DIV_1) ? RX_BITS : RX_START;
          end
          RX_START: if (phase_q == half_m1) begin
            phase_q <= '0;
            state_q <= rxd ? RX_IDLE : RX_BITS;
          end else begin
            phase_q <= phase_q + 7'd1;
          end
          RX_BITS: if (phase_q == full_m1) begin
            phase_q <= '0;
            bits_q  <= cur;
            if (idx_q == last_idx) state_q <= RX_IDLE;
            else idx_q <= idx_q + 4'd1;
          end else begin
            phase_q <= phase_q + 7'd1;
          end
          default: state_q <= RX_IDLE;
        endcase
      end
      if (rd_ack) begin
        rdrf <= 1'b0;
        ovrn <= 1'b0;
        pe   <= 1'b0;
      end
      if (lost_evt) ovrn <= 1'b1;
      if (load_evt) begin
        rx_data <= dword;
        rdrf    <= 1'b1;
        fe      <= !rxd;
        pe      <= par_bad;
      end
    end
  end
endmodule

// File: rtl/sio_adapter.sv
module sio_adapter
  import sio_pkg::*;
#(
  parameter int PRESCALE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              rxd,
  output logic              txd,
  input  logic              cts_in,
  input  logic              dcd_in,
  output logic              rts_out,
  output logic              irq_out
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  ctrl_t             ctrl_q;
  logic              ctrl_we, data_we, rd_ack, clr, tick, brk, rx_ie_en;
  logic              tdre, tx_busy, tx_load;
  logic              rdrf, fe, ovrn, pe, rx_end, rx_load, rx_lost;
  logic [DATA_W-1:0] rx_data;
  logic [DATA_W-1:0] status;

  assign ctrl_we  = wr_en && !reg_sel;
  assign clr      = (ctrl_q.div == DIV_RST);
  assign data_we  = wr_en && reg_sel && !clr;
  assign rd_ack   = rd_en && reg_sel && !clr;
  assign brk      = (ctrl_q.txc == TXC_LO_BREAK);
  assign rx_ie_en = ctrl_q.rx_ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= ctrl_t'({6'b000000, DIV_RST});
    else if (ctrl_we) ctrl_q <= ctrl_t'(wdata);
  end

  generate
    if (PRESCALE > 1) begin : g_pre
      logic [PRE_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else if (cnt_q == PRE_W'(PRESCALE - 1)) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
      end
      assign tick = (cnt_q == PRE_W'(PRESCALE - 1));
    end else begin : g_nopre
      assign tick = 1'b1;
    end
  endgenerate

  sio_tx u_tx (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick),
    .div(ctrl_q.div), .fmt(ctrl_q.fmt),
    .wr_data(data_we), .wdata(wdata), .brk(brk),
    .txd(txd), .tdre(tdre), .busy(tx_busy), .load_evt(tx_load)
  );

  sio_rx u_rx (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick),
    .div(ctrl_q.div), .fmt(ctrl_q.fmt),
    .rxd(rxd), .rd_ack(rd_ack),
    .rx_data(rx_data), .rdrf(rdrf), .fe(fe), .ovrn(ovrn), .pe(pe),
    .frame_end(rx_end), .load_evt(rx_load), .lost_evt(rx_lost)
  );

  assign irq_out = irq_req(rdrf, tdre, ctrl_q);
  assign rts_out = (ctrl_q.txc == TXC_HI_QUIET);
  assign status  = {irq_out, pe, ovrn, fe, cts_in, dcd_in, tdre, rdrf};
  assign rdata   = reg_sel ? rx_data : status;
endmodule

// File: rtl/sio_adapter_chk.sv
module sio_adapter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clr,
  input logic       ctrl_we,
  input logic       rx_ie_en,
  input logic       tx_load,
  input logic       tx_busy,
  input logic       tdre,
  input logic       txd,
  input logic       rd_ack,
  input logic       rx_end,
  input logic       rx_load,
  input logic       rx_lost,
  input logic       rdrf,
  input logic       ovrn,
  input logic       pe,
  input logic       irq_out,
  input logic [7:0] rx_data
);
  // R4
  tdre_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> tdre);

  // R5
  start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> (!txd || clr));

  // R9
  overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_lost |=> (clr || (ovrn && $stable(rx_data))));

  // R10
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !rx_end) |=> (!rdrf && !ovrn && !pe));

  // R2
  master_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!tx_busy && tdre && !rdrf && !ovrn));

  // R7
  rx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |=> (rdrf || clr));

  // R12
  rx_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_load && rx_ie_en && !ctrl_we) |=> irq_out);
endmodule

bind sio_adapter sio_adapter_chk i_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .ctrl_we(ctrl_we), .rx_ie_en(rx_ie_en),
  .tx_load(tx_load), .tx_busy(tx_busy), .tdre(tdre), .txd(txd),
  .rd_ack(rd_ack), .rx_end(rx_end), .rx_load(rx_load), .rx_lost(rx_lost),
  .rdrf(rdrf), .ovrn(ovrn), .pe(pe), .irq_out(irq_out), .rx_data(rx_data)
);

// File: tb/test_sio_adapter.sv
module test_sio_adapter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       rxd, txd, rts_out, irq_out;
  logic       cts_in = 1'b0, dcd_in = 1'b0;
  logic       loop = 1'b0, drv = 1'b1;
  int         checks = 0, errors = 0, cyc = 0;
  logic       samp [0:1023];

  always #2 clk = ~clk;
  assign rxd = loop ? txd : drv;

  sio_adapter #(.PRESCALE(1)) i_sio_adapter (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd),
    .cts_in(cts_in), .dcd_in(dcd_in), .rts_out(rts_out), .irq_out(irq_out)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic int tb_div(input logic [1:0] d);
    return (d == 2'd0) ? 1 : (d == 2'd1) ? 16 : 64;
  endfunction
  function automatic int tb_nd(input logic [2:0] f);
    return (f < 3'd4) ? 7 : 8;
  endfunction
  // 0 none, 1 even, 2 odd
  function automatic int tb_pm(input logic [2:0] f);
    case (f)
      3'd4, 3'd5: return 0;
      3'd1, 3'd3, 3'd7: return 2;
      default: return 1;
    endcase
  endfunction
  function automatic int tb_ns(input logic [2:0] f);
    return (f == 3'd0 || f == 3'd1 || f == 3'd4) ? 2 : 1;
  endfunction
  function automatic int tb_len(input logic [2:0] f);
    return 1 + tb_nd(f) + ((tb_pm(f) != 0) ? 1 : 0) + tb_ns(f);
  endfunction
  function automatic logic [7:0] tb_mask(input logic [2:0] f, input logic [7:0] d);
    return (tb_nd(f) == 7) ? (d & 8'h7F) : d;
  endfunction
  function automatic logic [11:0] tb_bits(input logic [2:0] f, input logic [7:0] d,
                                          input bit flip_par, input bit bad_stop);
    logic [11:0] v;
    int n;
    int ones;
    v = '1;
    v[0] = 1'b0;
    ones = 0;
    for (int i = 0; i < tb_nd(f); i++) begin
      v[1+i] = d[i];
      if (d[i]) ones++;
    end
    n = 1 + tb_nd(f);
    if (tb_pm(f) != 0) begin
      v[n] = ((ones % 2 == 1) ^ (tb_pm(f) == 2)) ^ flip_par;
      n++;
    end
    v[n] = !bad_stop;
    return v;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    @(negedge clk);
    reg_sel = s; wr_en = 1'b1; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_status(output logic [7:0] v);
    @(negedge clk);
    reg_sel = 1'b0;
    #1 v = rdata;
  endtask

  task automatic rd_data(output logic [7:0] v);
    @(negedge clk);
    reg_sel = 1'b1; rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0; reg_sel = 1'b0;
  endtask

  task automatic drive_rx(input logic [2:0] f, input int dv, input logic [7:0] d,
                          input bit flip_par, input bit bad_stop);
    logic [11:0] v;
    v = tb_bits(f, d, flip_par, bad_stop);
    for (int k = 0; k < tb_len(f); k++) begin
      @(negedge clk);
      drv = v[k];
      repeat (dv - 1) @(negedge clk);
    end
    @(negedge clk);
    drv = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic tx_check(input logic [7:0] c, input logic [7:0] d, input string tag);
    int dv;
    int len;
    logic [11:0] act;
    logic [11:0] exp;
    dv  = tb_div(c[1:0]);
    len = tb_len(c[4:2]);
    wr(1'b0, c);
    wr(1'b1, d);
    for (int j = 0; j < len * dv; j++) begin
      @(negedge clk);
      samp[j] = txd;
    end
    act = '1;
    for (int k = 0; k < len; k++) act[k] = samp[k * dv + dv / 2];
    exp = tb_bits(c[4:2], d, 1'b0, 1'b0);
    chk(tag, int'(act), int'(exp));
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    int lows;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_status(v);
    chk("R1 status after reset", v, 8'h02);
    chk("R1 txd idle", txd, 1);
    chk("R1 rts/irq low", {rts_out, irq_out}, 0);

    // R11 modem inputs
    cts_in = 1'b1; dcd_in = 1'b0;
    rd_status(v);
    chk("R11 cts bit3", v, 8'h0A);
    cts_in = 1'b0; dcd_in = 1'b1;
    rd_status(v);
    chk("R11 dcd bit2", v, 8'h06);
    dcd_in = 1'b0;

    // R3 R5 transmit waveforms in three framings and ratios
    tx_check(8'h1C, 8'hA5, "R5 R3 tx 8O1 div1");
    tx_check(8'h01, 8'h5A, "R5 R3 tx 7E2 div16");
    tx_check(8'h12, 8'hC3, "R5 R3 tx 8N2 div64");

    // R4 transmit-empty with a busy shifter
    wr(1'b0, 8'h15);
    wr(1'b1, 8'h01);
    wr(1'b1, 8'h02);
    rd_status(v);
    chk("R4 tdre low while queued", v[1], 0);
    repeat (10 * 16 + 8) @(negedge clk);
    rd_status(v);
    chk("R4 tdre back after transfer", v[1], 1);
    repeat (10 * 16 + 8) @(negedge clk);

    // R6 transmit control
    wr(1'b0, 8'h74);
    repeat (3) @(negedge clk);
    chk("R6 break forces txd low", {txd, rts_out}, 0);
    wr(1'b0, 8'h54);
    chk("R6 rts high in mode 2", {txd, rts_out}, 2'b11);
    // R12 transmit interrupt
    wr(1'b0, 8'h34);
    rd_status(v);
    chk("R12 tx irq on", {irq_out, v[7]}, 2'b11);
    wr(1'b0, 8'h14);
    chk("R12 tx irq off", {irq_out, rts_out}, 0);

    // R8 R10 parity error, 8E1 at div1
    wr(1'b0, 8'h18);
    drive_rx(3'd6, 1, 8'h81, 1'b1, 1'b0);
    rd_status(v);
    chk("R8 parity error flagged", v, 8'h43);
    rd_data(v);
    chk("R7 data with parity error", v, 8'h81);
    rd_status(v);
    chk("R10 read clears pe/rdrf", v, 8'h02);

    // R8 R10 framing error, 8N1 at div1
    wr(1'b0, 8'h14);
    drive_rx(3'd5, 1, 8'h55, 1'b0, 1'b1);
    rd_status(v);
    chk("R8 framing error flagged", v, 8'h13);
    rd_data(v);
    rd_status(v);
    chk("R10 fe persists after read", v, 8'h12);
    drive_rx(3'd5, 1, 8'h66, 1'b0, 1'b0);
    rd_status(v);
    chk("R10 fe cleared by good char", v, 8'h03);
    rd_data(v);
    chk("R7 data 8N1", v, 8'h66);

    // R9 overrun
    drive_rx(3'd5, 1, 8'h11, 1'b0, 1'b0);
    drive_rx(3'd5, 1, 8'h22, 1'b0, 1'b0);
    rd_status(v);
    chk("R9 overrun flagged", v, 8'h23);
    rd_data(v);
    chk("R9 first char kept", v, 8'h11);
    rd_status(v);
    chk("R10 read clears ovrn", v, 8'h02);

    // R12 receive interrupt
    wr(1'b0, 8'h94);
    drive_rx(3'd5, 1, 8'h3E, 1'b0, 1'b0);
    chk("R12 rx irq on", irq_out, 1);
    rd_data(v);
    chk("R12 rx irq off after read", irq_out, 0);

    // R13 short glitch at div16, then a good char
    wr(1'b0, 8'h15);
    @(negedge clk); drv = 1'b0;
    repeat (4) @(negedge clk);
    drv = 1'b1;
    repeat (60) @(negedge clk);
    rd_status(v);
    chk("R13 glitch ignored", v[0], 0);
    drive_rx(3'd5, 16, 8'h3C, 1'b0, 1'b0);
    rd_data(v);
    chk("R13 R7 char after glitch", v, 8'h3C);

    // R2 master reset
    wr(1'b0, 8'h14);
    drive_rx(3'd5, 1, 8'h44, 1'b0, 1'b0);
    wr(1'b0, 8'h03);
    rd_status(v);
    chk("R2 master reset clears status", v, 8'h02);
    wr(1'b1, 8'h00);
    lows = 0;
    for (int j = 0; j < 20; j++) begin
      @(negedge clk);
      if (!txd) lows++;
    end
    rd_status(v);
    chk("R2 data write ignored in reset", {lows[7:0], v}, 16'h0002);
    wr(1'b0, 8'h14);
    lows = 0;
    for (int j = 0; j < 30; j++) begin
      @(negedge clk);
      if (!txd) lows++;
    end
    chk("R2 nothing sent after release", lows, 0);

    // R3 R7 R12 random loopback over all framings and ratios
    loop = 1'b1;
    for (int it = 0; it < 12; it++) begin
      logic [2:0] f;
      logic [1:0] d;
      logic [7:0] byte_v, c;
      logic ie, ti;
      f = 3'($urandom % 8);
      d = 2'($urandom % 3);
      byte_v = 8'($urandom);
      ie = 1'($urandom);
      ti = 1'($urandom);
      cts_in = 1'($urandom);
      dcd_in = 1'($urandom);
      c = {ie, 1'b0, ti, f, d};
      wr(1'b0, c);
      wr(1'b1, byte_v);
      repeat (12 * tb_div(d) + 4) @(negedge clk);
      rd_status(v);
      chk("R3 R12 loopback status", v, {(ie | ti), 3'b000, cts_in, dcd_in, 2'b11});
      rd_data(v);
      chk("R3 R7 loopback data", v, tb_mask(f, byte_v));
      rd_status(v);
      chk("R10 loopback after read", v, {ti, 3'b000, cts_in, dcd_in, 2'b10});
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule